// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to normal operation. After reset it idles with every command pin deselected. A single start pulse launches a fixed walk through the power-up steps. First comes a settling delay for power and clocks. Then one NOP, one all-banks precharge, a burst of eight CBR auto-refresh commands, and one mode-register load carrying a caller-supplied value. The block then changes to normal mode and, as the very last step, enables periodic refresh and raises a sticky done flag.

Each step is held for a spacing taken from parameters derived from the clock frequency: settling time in microseconds, row cycle time in nanoseconds, and the NOP and mode-register spacings in clocks. The precharge-to-refresh spacing is picked at run time by a one-bit input. A three-bit command-mode code is exported so that the surrounding memory controller can tell which init phase is in force. Data transfers are handled elsewhere.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset, and until a start pulse is seen, the pins cs_no, ras_no, cas_no and we_no are all 1. addr_o is 0, refresh_en_o and done_o are 0, and mode_sel_o is 3'b001.
- R2: With start_i sampled high at clock edge 0, the first command (a NOP) is on the pins in the cycle after edge SETTLE_CYC, where SETTLE_CYC = CLK_MHZ*SETTLE_US.
- R3: The all-banks precharge follows the NOP by exactly NOP_WAIT_CYC clocks.
- R4: The first CBR refresh follows the precharge by 2 clocks when trp_two_i is 1 and by 3 clocks when it is 0. trp_two_i is sampled in the precharge cycle.
- R5: Exactly CBR_COUNT (default 8) CBR commands are issued, each TRC_CYC clocks after the previous one. The mode-register set follows the last CBR by TRC_CYC clocks. TRC_CYC = ceil(TRC_NS*CLK_MHZ/1000), with a floor of 2.
- R6: In the mode-register-set cycle, addr_o equals mode_val_i. In every other cycle addr_o is 0.
- R7: mode_sel_o tracks the phase in force, using these codes: 001 NOP from reset through the NOP spacing, 010 precharge, 100 CBR, 011 mode-register set, and 000 normal. It becomes 000 exactly MRS_WAIT_CYC clocks after the mode-register-set cycle.
- R8: refresh_en_o and done_o rise together, one clock after mode_sel_o first reads 000. Neither is ever high before that.
- R9: Once done_o is high, it stays high until reset. Later start pulses produce no command and change no output.
- R10: Command pin encodings are given as {cs_no,ras_no,cas_no,we_no}: NOP 0111, precharge 0010, CBR 0001, mode-register set 0000. A mode code in the reserved range 101..111 issues nothing.
- R11: Each command occupies a single clock. Every other cycle drives 1111 on the pins.
- R12: A start pulse that arrives while the sequence is running is ignored. The command timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches the sequence when sampled high in idle |
| mode_val_i | input | ADDR_W | Value loaded into the device mode register |
| trp_two_i | input | 1 | 1: precharge spacing of 2 clocks; 0: 3 clocks |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus, carries mode_val_i during the mode-register set |
| mode_sel_o | output | 3 | Current command-mode code |
| refresh_en_o | output | 1 | Periodic refresh enable |
| done_o | output | 1 | Sequence complete, sticky |

## Verification
The assertions assume that every spacing parameter works out to at least two clocks, so that two command cycles are never adjacent. They assume that mode_val_i is steady in the mode-register-set cycle and trp_two_i is steady in the precharge cycle. The bench holds both inputs fixed for a whole run and changes them only while reset is asserted. It sweeps both precharge settings against several address patterns and compares the pins in every cycle against a schedule computed from the spacing formulas. It adds one run with start pulses injected mid-sequence and a burst of start pulses after completion.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'b000,
    MODE_NOP    = 3'b001,
    MODE_PRE    = 3'b010,
    MODE_MRS    = 3'b011,
    MODE_CBR    = 3'b100
  } cmd_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_NOP,
    ST_NOP_WAIT,
    ST_PRE,
    ST_PRE_WAIT,
    ST_CBR,
    ST_CBR_WAIT,
    ST_MRS,
    ST_MRS_WAIT,
    ST_NORMAL,
    ST_DONE
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_pins_t;

  localparam sdram_pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // down-counter must park at zero, never wrap
  a_r11_timer_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);

  // a loaded value is followed by exactly one decrement per clock
  a_r5_timer_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pwrup_cmd_encode.sv
module pwrup_cmd_encode
  import sdram_pwrup_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [2:0]        mode_i,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] mode_val_i,
  output sdram_pins_t       pins_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    pins_o = PINS_DESEL;
    addr_o = '0;
    if (issue_i) begin
      unique case (mode_i)
        MODE_NOP: pins_o = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        MODE_PRE: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
        MODE_CBR: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
        MODE_MRS: begin
          pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
          addr_o = mode_val_i;
        end
        default: pins_o = PINS_DESEL;  // normal and reserved codes: nothing on the bus
      endcase
    end
  end

  always_comb begin
    if (issue_i && (mode_i > 3'd4)) begin
      a_r10_reserved_silent: assert (pins_o.cs_n && (addr_o == '0));
    end
  end

endmodule

// File: rtl/pwrup_step_fsm.sv
module pwrup_step_fsm
  import sdram_pwrup_pkg::*;
#(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned SETTLE_CYC   = 20000,
  parameter int unsigned NOP_WAIT_CYC = 200,
  parameter int unsigned TRC_CYC      = 7,
  parameter int unsigned MRS_WAIT_CYC = 2,
  parameter int unsigned CBR_COUNT    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             trp_two_i,
  input  logic             wait_zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [2:0]       mode_o,
  output logic             issue_o,
  output logic             refresh_en_o,
  output logic             done_o
);

  localparam int unsigned CBR_W = $clog2(CBR_COUNT + 1);

  step_e            state_q, state_d;
  logic [CBR_W-1:0] cbr_cnt_q;
  logic             cbr_last;

  assign cbr_last = (cbr_cnt_q == CBR_W'(CBR_COUNT));

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d    = ST_SETTLE;
        load_o     = 1'b1;
        load_val_o = CNT_W'(SETTLE_CYC - 1);
      end
      ST_SETTLE:   if (wait_zero_i) state_d = ST_NOP;
      ST_NOP: begin
        state_d    = ST_NOP_WAIT;
        load_o     = 1'b1;
        load_val_o = CNT_W'(NOP_WAIT_CYC - 2);
      end
      ST_NOP_WAIT: if (wait_zero_i) state_d = ST_PRE;
      ST_PRE: begin
        state_d    = ST_PRE_WAIT;
        load_o     = 1'b1;
        load_val_o = trp_two_i ? CNT_W'(0) : CNT_W'(1);
      end
      ST_PRE_WAIT: if (wait_zero_i) state_d = ST_CBR;
      ST_CBR: begin
        state_d    = ST_CBR_WAIT;
        load_o     = 1'b1;
        load_val_o = CNT_W'(TRC_CYC - 2);
      end
      ST_CBR_WAIT: if (wait_zero_i) state_d = cbr_last ? ST_MRS : ST_CBR;
      ST_MRS: begin
        state_d    = ST_MRS_WAIT;
        load_o     = 1'b1;
        load_val_o = CNT_W'(MRS_WAIT_CYC - 2);
      end
      ST_MRS_WAIT: if (wait_zero_i) state_d = ST_NORMAL;
      ST_NORMAL:   state_d = ST_DONE;
      ST_DONE:     state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cbr_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CBR) cbr_cnt_q <= cbr_cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE, ST_PRE_WAIT: mode_o = MODE_PRE;
      ST_CBR, ST_CBR_WAIT: mode_o = MODE_CBR;
      ST_MRS, ST_MRS_WAIT: mode_o = MODE_MRS;
      ST_NORMAL, ST_DONE:  mode_o = MODE_NORMAL;
      default:             mode_o = MODE_NOP;
    endcase
  end

  assign issue_o      = (state_q == ST_NOP) || (state_q == ST_PRE) ||
                        (state_q == ST_CBR) || (state_q == ST_MRS);
  assign refresh_en_o = (state_q == ST_DONE);
  assign done_o       = (state_q == ST_DONE);

  a_r5_cbr_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_cnt_q <= CBR_W'(CBR_COUNT));

  a_r5_mrs_after_all_cbr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MRS) |-> cbr_last);

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r12_start_ignored_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> (state_q != ST_SETTLE || $past(state_q) == ST_SETTLE));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_pwrup_pkg::*;
#(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned SETTLE_US    = 200,
  parameter int unsigned NOP_WAIT_CYC = 200,
  parameter int unsigned TRC_NS       = 70,
  parameter int unsigned MRS_WAIT_CYC = 2,
  parameter int unsigned CBR_COUNT    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] mode_val_i,
  input  logic              trp_two_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        mode_sel_o,
  output logic              refresh_en_o,
  output logic              done_o
);

  localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int unsigned TRC_RAW    = (TRC_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned TRC_CYC    = (TRC_RAW < 2) ? 2 : TRC_RAW;
  localparam int unsigned MAX_LOAD   = max_u(max_u(SETTLE_CYC, NOP_WAIT_CYC),
                                             max_u(max_u(TRC_CYC, MRS_WAIT_CYC), 3));
  localparam int unsigned CNT_W      = $clog2(MAX_LOAD + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             wait_zero;
  logic             issue;
  sdram_pins_t      pins;

  pwrup_wait_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (wait_zero)
  );

  pwrup_step_fsm #(
    .CNT_W       (CNT_W),
    .SETTLE_CYC  (SETTLE_CYC),
    .NOP_WAIT_CYC(NOP_WAIT_CYC),
    .TRC_CYC     (TRC_CYC),
    .MRS_WAIT_CYC(MRS_WAIT_CYC),
    .CBR_COUNT   (CBR_COUNT)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .trp_two_i   (trp_two_i),
    .wait_zero_i (wait_zero),
    .load_o      (load),
    .load_val_o  (load_val),
    .mode_o      (mode_sel_o),
    .issue_o     (issue),
    .refresh_en_o(refresh_en_o),
    .done_o      (done_o)
  );

  pwrup_cmd_encode #(
    .ADDR_W(ADDR_W)
  ) u_enc (
    .mode_i    (mode_sel_o),
    .issue_i   (issue),
    .mode_val_i(mode_val_i),
    .pins_o    (pins),
    .addr_o    (addr_o)
  );

  assign cs_no  = pins.cs_n;
  assign ras_no = pins.ras_n;
  assign cas_no = pins.cas_n;
  assign we_no  = pins.we_n;

  a_r6_addr_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs_no && !ras_no && !cas_no && !we_no) |-> (addr_o == '0));

  a_r6_addr_mrs_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !ras_no && !cas_no && !we_no) |-> (addr_o == mode_val_i));

  a_r11_single_cycle_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |=> cs_no);

  a_r8_refresh_after_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refresh_en_o) |-> ($past(mode_sel_o) == MODE_NORMAL));

  a_r8_done_with_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == refresh_en_o);

  a_r9_quiet_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && mode_sel_o == MODE_NORMAL));

  a_r7_normal_is_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_o == MODE_NORMAL) |-> cs_no);

endmodule

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

  localparam int AW      = 13;
  localparam int S_CYC   = 12;  // CLK_MHZ=1, SETTLE_US=12
  localparam int NW_CYC  = 6;
  localparam int TRC     = 4;   // ceil(4000*1/1000)
  localparam int MW_CYC  = 2;
  localparam int NCBR    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] mode_val = '0;
  logic          trp_two = 1'b0;
  logic          cs_n, ras_n, cas_n, we_n;
  logic [AW-1:0] addr;
  logic [2:0]    mode_sel;
  logic          refresh_en, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sdram_pwrup_seq #(
    .ADDR_W(AW), .CLK_MHZ(1), .SETTLE_US(S_CYC), .NOP_WAIT_CYC(NW_CYC),
    .TRC_NS(4000), .MRS_WAIT_CYC(MW_CYC), .CBR_COUNT(NCBR)
  ) u_sdram_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_val_i(mode_val),
    .trp_two_i(trp_two), .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .addr_o(addr), .mode_sel_o(mode_sel), .refresh_en_o(refresh_en), .done_o(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pins_of(input int code);
    case (code)
      1: return 4'b0111;
      2: return 4'b0010;
      3: return 4'b0000;
      4: return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic check_idle(input string req);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, req, "pins idle", {cs_n, ras_n, cas_n, we_n}, 4'hf);
    chk(addr == '0, req, "addr idle", addr, 0);
    chk(refresh_en == 1'b0, req, "refresh_en idle", refresh_en, 0);
    chk(done == 1'b0, req, "done idle", done, 0);
    chk(mode_sel == 3'b001, req, "mode_sel idle", mode_sel, 1);
  endtask

  task automatic run_seq(input logic trp, input logic [AW-1:0] mv, input bit glitch);
    int t_pre, t_cbr0, t_mrs, t_norm, t_done;
    t_pre  = S_CYC + NW_CYC;
    t_cbr0 = t_pre + (trp ? 2 : 3);
    t_mrs  = t_cbr0 + NCBR * TRC;
    t_norm = t_mrs + MW_CYC;
    t_done = t_norm + 1;

    rst_n = 1'b0; start = 1'b0; trp_two = trp; mode_val = mv;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= t_done + 8; j++) begin
      int ec, em;
      string tag;
      logic [AW-1:0] ea;
      ec = 0;
      if (j == S_CYC) ec = 1;
      else if (j == t_pre) ec = 2;
      else if (j >= t_cbr0 && j < t_mrs && ((j - t_cbr0) % TRC) == 0) ec = 4;
      else if (j == t_mrs) ec = 3;
      if (j < t_pre) em = 1;
      else if (j < t_cbr0) em = 2;
      else if (j < t_mrs) em = 4;
      else if (j < t_norm) em = 3;
      else em = 0;
      ea = (j == t_mrs) ? mv : '0;
      if (j <= S_CYC) tag = "R2 R10 R11";
      else if (j <= t_pre) tag = "R3 R10 R11";
      else if (j <= t_cbr0) tag = "R4 R10 R11";
      else if (j <= t_mrs) tag = "R5 R10 R11";
      else tag = "R9 R11";
      if (glitch) tag = {tag, " R12"};
      chk({cs_n, ras_n, cas_n, we_n} == pins_of(ec), tag, $sformatf("pins at %0d", j),
          {cs_n, ras_n, cas_n, we_n}, pins_of(ec));
      chk(addr == ea, glitch ? "R6 R12" : "R6", $sformatf("addr at %0d", j), addr, ea);
      chk(mode_sel == 3'(em), glitch ? "R7 R12" : "R7", $sformatf("mode_sel at %0d", j), mode_sel, em);
      chk(refresh_en == (j >= t_done), "R8", $sformatf("refresh_en at %0d", j), refresh_en, j >= t_done);
      chk(done == (j >= t_done), "R8", $sformatf("done at %0d", j), done, j >= t_done);
      start = glitch && (j == 3 || j == S_CYC || j == t_pre + 1 || j == t_cbr0 + TRC + 1 || j == t_mrs);
      @(negedge clk);
    end
    start = 1'b0;

    // start pulses after completion must do nothing
    for (int k = 0; k < 12; k++) begin
      start = (k % 3 == 0);
      @(negedge clk);
      chk({cs_n, ras_n, cas_n, we_n} == 4'hf, "R9", "pins after done", {cs_n, ras_n, cas_n, we_n}, 4'hf);
      chk(done && refresh_en, "R9", "done/refresh sticky", {done, refresh_en}, 3);
      chk(mode_sel == 3'b000 && addr == '0, "R9", "mode/addr after done", mode_sel, 0);
    end
    start = 1'b0;
  endtask

  initial begin : watchdog
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] pats [4];
    pats[0] = 13'h0000; pats[1] = 13'h01d0; pats[2] = 13'h1fff; pats[3] = 13'h0a5a;
    for (int t = 0; t < 2; t++) begin
      for (int p = 0; p < 4; p++) begin
        run_seq(t[0], pats[p], 1'b0);
      end
    end
    run_seq(1'b1, 13'h1234, 1'b1);
    run_seq(1'b0, 13'h0b6d, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule